// File: doc/BRIEF.md
# Break-Aware Status Flag Clear Controller

This block holds a small set of peripheral status flags. Each flag is set by a one-cycle event from its peripheral and is cleared by a two-step handshake. The first step is a read of the status register that finds the flag at 1. The second step is a later access to that flag's own data register. A per-flag state machine records whether the first step has been taken, so the clear is armed.

While a debug halt is active, the block protects set flags. The only way to allow clears during the halt is a clear-enable control bit. If a flag is armed before the halt and the halt blocks the second step, the flag stays armed. The same second step then clears the flag once the halt ends. A flag that was cleared during an enabled halt stays cleared after the halt.

The block also assembles a read-only status byte, with one request bit per flag. The status byte has no write path, so a write to its address cannot change anything.

Each flag cell runs through three named states:
- `FLG_IDLE`: the flag is 0.
- `FLG_PEND`: the flag is 1 but not armed.
- `FLG_ARMED`: the flag is 1 and the status read has been seen.

The cells move between these states on five named transitions:
- *set* goes from IDLE to PEND on a set event.
- *arm* goes from PEND to ARMED on a status read when there is no set event in the same cycle.
- *rearm-required* goes from ARMED to PEND on a set event.
- *clear* goes from ARMED to IDLE on a data access while clearing is permitted.
- *hold* keeps ARMED when the data access comes while clearing is blocked.

Top module: `brk_flag_ctrl`

## Requirements
- R1: A synchronous active-low reset sets every flag to 0 and drops every armed first step. After reset, a second-step access alone does not clear a newly set flag.
- R2: A set event on flag i makes flag i read 1 after the next rising clock edge. Status byte bit i (for i from 0 to NUM_FLAGS-1) equals flag i. Every higher bit of the status byte reads 0.
- R3: A status read while flag i is 1 arms flag i. A later second-step access on flag i then clears the flag at the next edge. A second-step access on a flag that is not armed has no effect.
- R4: A status read while flag i is 0 does not arm flag i, so a later set followed by a second-step access leaves the flag at 1.
- R5: A set event on an armed flag, or a set event in the same cycle as the status read, leaves the flag unarmed. The first step must then be repeated.
- R6: When a set event and a valid second-step access fall in the same cycle, the flag stays 1.
- R7: While the halt input is 1 and the clear-enable bit is 0, no second-step access clears a flag. A status read still arms the flag, and any existing arm is kept.
- R8: While the halt input is 1 and the clear-enable bit is 1, the two-step clear works exactly as it does outside the halt.
- R9: A flag cleared during the halt stays 0 after the halt ends.
- R10: A flag armed before or during a protected halt is cleared by a second-step access after the halt ends, without a new status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| set_evt | input | NUM_FLAGS | One-cycle set event, one bit per flag |
| stat_rd | input | 1 | Bus read strobe of the status register (first step) |
| data_acc | input | NUM_FLAGS | Access strobe of each flag's data register (second step) |
| brk_active | input | 1 | Debug halt in progress (level) |
| clr_en | input | 1 | Allows clearing while the halt is active |
| flag_q | output | NUM_FLAGS | Current flag values |
| stat_byte | output | STAT_W | Read-only status byte; bit i = flag i; unused bits 0 |

## Verification
Several properties are checked on every cycle:
- During a protected halt, no set flag falls.
- A flag falls only in the cycle after its own data access.
- A flag rises only in the cycle after its own set event.
- A set event always leaves its flag at 1.
- The status byte mirrors the flags, with zeros above them.
- Reset leaves every flag at 0.

Some behaviours depend on the hidden armed state, so only the bench's sequences can show them:
- an arm carried across halt entry and exit;
- a re-arm demanded after a fresh set;
- a read of a clear flag that does not arm;
- reset dropping an armed first step.

// File: rtl/brk_flag_pkg.sv
package brk_flag_pkg;

    // Per-flag clearing sequence state.
    typedef enum logic [1:0] {
        FLG_IDLE  = 2'd0,   // flag is 0
        FLG_PEND  = 2'd1,   // flag is 1, first step not seen
        FLG_ARMED = 2'd2    // flag is 1, status read seen
    } flg_state_e;

endpackage

// File: rtl/brk_clear_gate.sv
// Decides whether a second-step access may clear a flag this cycle.
module brk_clear_gate (
    input  logic brk_active,
    input  logic clr_en,
    output logic clr_ok
);

    always_comb begin
        clr_ok = !brk_active || clr_en;
    end

endmodule

// File: rtl/brk_flag_cell.sv
// One status flag with its two-step clearing state machine.
module brk_flag_cell
    import brk_flag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic stat_rd,
    input  logic data_acc,
    input  logic clr_ok,
    output logic flag
);

    flg_state_e cur_st;
    flg_state_e nxt_st;

    // Next-state logic.
    always_comb begin
        nxt_st = cur_st;
        unique case (cur_st)
            FLG_IDLE: begin
                if (set_evt) nxt_st = FLG_PEND;              // set
            end
            FLG_PEND: begin
                if (!set_evt && stat_rd) nxt_st = FLG_ARMED; // arm
            end
            FLG_ARMED: begin
                if (set_evt)                 nxt_st = FLG_PEND;  // rearm-required
                else if (data_acc && clr_ok) nxt_st = FLG_IDLE;  // clear
                // otherwise hold, also across a protected halt
            end
            default: nxt_st = FLG_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) cur_st <= FLG_IDLE;
        else        cur_st <= nxt_st;
    end

    // Output.
    always_comb begin
        flag = (cur_st != FLG_IDLE);
    end

endmodule

// File: rtl/brk_stat_pack.sv
// Builds the read-only status byte: one request bit per flag, zeros above.
module brk_stat_pack #(
    parameter int NUM_FLAGS = 2,
    parameter int STAT_W    = 8
) (
    input  logic [NUM_FLAGS-1:0] flags,
    output logic [STAT_W-1:0]    stat_byte
);

    for (genvar b = 0; b < STAT_W; b++) begin : g_bit
        if (b < NUM_FLAGS) begin : g_used
            assign stat_byte[b] = flags[b];
        end else begin : g_zero
            assign stat_byte[b] = 1'b0;
        end
    end

endmodule

// File: rtl/brk_flag_ctrl.sv
// Top: flags with break-aware two-step clearing and a status byte.
module brk_flag_ctrl #(
    parameter int NUM_FLAGS = 2,
    parameter int STAT_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] set_evt,
    input  logic                 stat_rd,
    input  logic [NUM_FLAGS-1:0] data_acc,
    input  logic                 brk_active,
    input  logic                 clr_en,
    output logic [NUM_FLAGS-1:0] flag_q,
    output logic [STAT_W-1:0]    stat_byte
);

    logic clr_ok;

    brk_clear_gate u_gate (
        .brk_active (brk_active),
        .clr_en     (clr_en),
        .clr_ok     (clr_ok)
    );

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        brk_flag_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_evt  (set_evt[i]),
            .stat_rd  (stat_rd),
            .data_acc (data_acc[i]),
            .clr_ok   (clr_ok),
            .flag     (flag_q[i])
        );
    end

    brk_stat_pack #(
        .NUM_FLAGS (NUM_FLAGS),
        .STAT_W    (STAT_W)
    ) u_pack (
        .flags     (flag_q),
        .stat_byte (stat_byte)
    );

endmodule

// File: rtl/brk_flag_chk.sv
// Checker bound to brk_flag_ctrl.
module brk_flag_chk #(
    parameter int NUM_FLAGS = 2,
    parameter int STAT_W    = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_FLAGS-1:0] set_evt,
    input logic [NUM_FLAGS-1:0] data_acc,
    input logic                 brk_active,
    input logic                 clr_en,
    input logic [NUM_FLAGS-1:0] flag_q,
    input logic [STAT_W-1:0]    stat_byte
);

    // R1: reset leaves all flags clear.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (flag_q == '0));

    // R2: a flag rises only after its own set event.
    assert_rise_needs_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (~&flag_q) |=> (((~$past(flag_q)) & flag_q & ~$past(set_evt)) == '0));

    // R2: status byte mirrors flags, unused bits zero.
    assert_stat_map_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stat_byte == {{(STAT_W-NUM_FLAGS){1'b0}}, flag_q});

    // R3: a flag falls only after its own second-step access.
    assert_clear_needs_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|flag_q) |=> ((($past(flag_q) & ~flag_q) & ~$past(data_acc)) == '0));

    // R6: a set event always leaves its flag at 1.
    assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_evt) |=> ((flag_q & $past(set_evt)) == $past(set_evt)));

    // R7: no set flag falls during a protected halt.
    assert_protect_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_active && !clr_en) |=> (($past(flag_q) & ~flag_q) == '0));

endmodule

bind brk_flag_ctrl brk_flag_chk #(
    .NUM_FLAGS (NUM_FLAGS),
    .STAT_W    (STAT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_evt    (set_evt),
    .data_acc   (data_acc),
    .brk_active (brk_active),
    .clr_en     (clr_en),
    .flag_q     (flag_q),
    .stat_byte  (stat_byte)
);

// File: tb/sim_brk_flag_ctrl.sv
`timescale 1ns/1ps
module sim_brk_flag_ctrl;

    localparam int NF = 2;
    localparam int SW = 8;
    localparam int NV = 28;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NF-1:0] set_evt = '0;
    logic          stat_rd = 1'b0;
    logic [NF-1:0] data_acc = '0;
    logic          brk_active = 1'b0;
    logic          clr_en = 1'b0;
    logic [NF-1:0] flag_q;
    logic [SW-1:0] stat_byte;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    brk_flag_ctrl #(.NUM_FLAGS(NF), .STAT_W(SW)) u0 (
        .clk (clk), .rst_n (rst_n), .set_evt (set_evt), .stat_rd (stat_rd),
        .data_acc (data_acc), .brk_active (brk_active), .clr_en (clr_en),
        .flag_q (flag_q), .stat_byte (stat_byte)
    );

    // Vector: {set[1:0], rd, acc[1:0], brk, cen, expected flags[1:0]}
    localparam logic [8:0] VEC [0:NV-1] = '{
        9'b01_0_00_0_0_01,  //  0 R2 set f0
        9'b00_0_01_0_0_01,  //  1 R3 access without arm ignored
        9'b00_1_00_0_0_01,  //  2 R3 arm f0
        9'b00_0_01_0_0_00,  //  3 R3 clear f0
        9'b00_1_00_0_0_00,  //  4 R4 read while clear
        9'b01_0_00_0_0_01,  //  5 R4 set f0
        9'b00_0_01_0_0_01,  //  6 R4 not armed by earlier read
        9'b00_1_00_0_0_01,  //  7 R5 arm f0
        9'b01_0_00_0_0_01,  //  8 R5 set again disarms
        9'b00_0_01_0_0_01,  //  9 R5 access ignored
        9'b10_1_00_0_0_11,  // 10 R5 arm f0, set f1 with read
        9'b00_0_11_0_0_10,  // 11 R5 f0 clears, f1 unarmed
        9'b00_1_00_0_0_10,  // 12 R6 arm f1
        9'b10_0_10_0_0_10,  // 13 R6 set beats clear
        9'b00_0_10_0_0_10,  // 14 R6 set disarmed f1
        9'b00_1_00_0_0_10,  // 15 R10 arm f1 before halt
        9'b00_0_10_1_0_10,  // 16 R7 protected
        9'b00_0_10_1_0_10,  // 17 R7 still protected
        9'b00_0_10_0_0_00,  // 18 R10 arm survived halt
        9'b11_0_00_0_0_11,  // 19 R2 set both
        9'b00_1_00_1_0_11,  // 20 R7 arm during protected halt
        9'b00_0_01_1_1_10,  // 21 R8 enabled clear in halt
        9'b00_0_00_0_0_10,  // 22 R9 stays cleared after exit
        9'b00_0_10_0_0_00,  // 23 R10 arm from halt used after exit
        9'b01_0_00_1_0_01,  // 24 R2 set during halt
        9'b00_1_00_1_1_01,  // 25 R8 arm in enabled halt
        9'b00_0_01_1_1_00,  // 26 R8 clear in enabled halt
        9'b00_0_00_0_0_00   // 27 R9 stays cleared
    };
    localparam int VREQ [0:NV-1] = '{2,3,3,3,4,4,4,5,5,5,5,5,6,6,6,10,
                                     7,7,10,2,7,8,9,10,2,8,8,9};

    task automatic chk(input int req, input logic [NF-1:0] exp);
        logic [SW-1:0] exp_b;
        exp_b = {{(SW-NF){1'b0}}, exp};
        checks++;
        if (flag_q !== exp || stat_byte !== exp_b) begin
            fails++;
            $display("FAIL R%0d flags=%b stat=%h expected flags=%b stat=%h",
                     req, flag_q, stat_byte, exp, exp_b);
        end
    endtask

    task automatic drive(input logic [NF-1:0] s, input logic r,
                         input logic [NF-1:0] a, input logic b, input logic c);
        set_evt = s; stat_rd = r; data_acc = a; brk_active = b; clr_en = c;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(1, 2'b00);                 // R1 reset state
        rst_n = 1'b1;
        for (int k = 0; k < NV; k++) begin
            drive(VEC[k][8:7], VEC[k][6], VEC[k][5:4], VEC[k][3], VEC[k][2]);
            @(negedge clk);
            chk(VREQ[k], VEC[k][1:0]);
        end
        // R1: reset drops flags and armed state
        drive(2'b11, 1'b0, 2'b00, 1'b0, 1'b0); @(negedge clk); chk(2, 2'b11);
        drive(2'b00, 1'b1, 2'b00, 1'b0, 1'b0); @(negedge clk); chk(3, 2'b11);
        drive(2'b00, 1'b0, 2'b00, 1'b0, 1'b0); rst_n = 1'b0;
        @(negedge clk); chk(1, 2'b00);
        rst_n = 1'b1;
        drive(2'b11, 1'b0, 2'b00, 1'b0, 1'b0); @(negedge clk); chk(1, 2'b11);
        drive(2'b00, 1'b0, 2'b11, 1'b0, 1'b0); @(negedge clk); chk(1, 2'b11);
        drive(2'b00, 1'b0, 2'b00, 1'b0, 1'b0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule